// File: doc/BRIEF.md
# Serial-Bus Tuner Control Slave

This block is a write-only I2C slave that lets a host processor program a frequency synthesizer and a set of three audio channels. A host telegram starts with an address byte and carries one or more data bytes. Each data byte is classified by its leading bit and position. It is either half of an 11-bit divider ratio or a control byte. The control byte selects a high or low charge-pump current, mutes any of three channels and picks a test mode.

The bus lines pass through two-flop synchronizers into a system clock that runs at least twenty times faster than SCL. Start, stop and SCL edges are all detected in that clock domain. A strap input picks one of two bus addresses, so two slaves can share one bus. The two divider bytes are assembled in a holding register. The ratio output changes only once both halves are in, so a half-written ratio never reaches the synthesizer. While reset is held, the slave leaves SDA released.

The link state machine has six states:
- `ST_IDLE`: waiting for a start.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_DATA`: shifting in a data byte.
- `ST_DATA_ACK`: acknowledging a data byte.
- `ST_IGNORE`: the telegram is not for this slave.

Its transitions are:
- A start moves any state to `ST_ADDR`.
- A stop moves any state to `ST_IDLE`.
- `ST_ADDR` moves to `ST_ADDR_ACK` on the SCL fall after the eighth bit if the byte matches, and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` moves to `ST_DATA` on the next SCL fall.
- `ST_DATA` moves to `ST_DATA_ACK` on the SCL fall after eight bits.
- `ST_DATA_ACK` returns to `ST_DATA` on the next SCL fall.

Top module: `tuner_ctl_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) begins address reception from any state, including in the middle of a telegram. A stop (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: Bits are taken most significant first on SCL rising edges. After the eighth bit of an accepted byte, the slave pulls SDA low from the following SCL fall until the SCL fall that ends the ninth clock.
- R3: With `addr_sel` low the slave acknowledges the write address byte 0x44, and with `addr_sel` high it acknowledges 0x46. Any other address, or a read request (bit 0 set), gets no acknowledge, and every byte up to the next start is ignored.
- R4: A data byte with bit 7 clear, outside the second position of a divider pair, is the divider high byte. Its bits 5..0 become ratio bits 10..5, and they are held pending without changing `div_ratio_o`.
- R5: The byte that directly follows a divider high byte is the divider low byte, whatever its bit 7. Its bits 7..3 are ratio bits 4..0, and the whole 11-bit ratio then appears on `div_ratio_o` at once.
- R6: A divider high byte followed by a stop, or by a repeated start, is discarded, and `div_ratio_o` keeps its value.
- R7: A data byte with bit 7 set, outside a divider pair, is the control byte. The fields are all applied together:
  - bit 6 drives `pump_hi_o`;
  - bit 5 mutes channel 1 (`chan_off_o[0]`);
  - bit 4 mutes channel 2 (`chan_off_o[1]`);
  - bit 3 mutes channel 3 (`chan_off_o[2]`);
  - bits 2..0 drive `test_mode_o`.
- R8: One telegram may carry the divider pair followed by the control byte, or the control byte followed by the divider pair, and both are applied.
- R9: While `rst_n` is low the slave never pulls SDA low. After reset, `div_ratio_o` is 1024 and all control outputs are zero.
- R10: Every data byte of a telegram addressed to this slave is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x SCL |
| rst_n | input | 1 | Active-low asynchronous reset (power-on reset) |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level (wired-AND bus value) |
| addr_sel | input | 1 | Address strap: 0 selects 0x44, 1 selects 0x46 |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| div_ratio_o | output | 11 | Committed synthesizer divider ratio |
| pump_hi_o | output | 1 | High charge-pump current select |
| chan_off_o | output | 3 | Mute per channel, bit 0 = channel 1 |
| test_mode_o | output | 3 | Test mode field |

## Verification
A repeated start can arrive while a divider pair is still open. In that same cycle the pending high byte must be abandoned and address reception must restart. The bench provokes this by sending a divider high byte and then a start at once. It follows with the address and a byte whose top bit is set. The result is judged at the ports: the ratio must stay unchanged, and that byte must land in the control outputs rather than being taken as a divider low byte. The opposite ordering is also run, where a control-shaped byte directly follows a divider high byte. In that case the byte must complete the ratio.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } link_state_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_DIV_HI,
        KIND_DIV_LO,
        KIND_CTRL
    } byte_kind_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/tcs_bus_sense.sv
module tcs_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_det,
    output logic stop_det
);
    // bit 1 = SCL, bit 0 = SDA
    logic [1:0] stage [SYNC_STAGES];
    logic [1:0] prev;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= 2'b11;
                else        stage[g] <= {scl_i, sda_i};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= 2'b11;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 2'b11;
        else        prev <= stage[SYNC_STAGES-1];
    end

    logic scl_s, sda_s, scl_q, sda_q;
    assign scl_s = stage[SYNC_STAGES-1][1];
    assign sda_s = stage[SYNC_STAGES-1][0];
    assign scl_q = prev[1];
    assign sda_q = prev[0];

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign sda_bit   = sda_s;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tcs_link_fsm.sv
module tcs_link_fsm
    import tcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_bit,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [6:0] addr7,
    output logic       sda_pull,
    output logic       evt_valid,
    output byte_kind_t evt_kind,
    output logic [7:0] evt_byte
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);

    link_state_t st, st_n;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             pair_open;
    logic             byte_done;
    logic             addr_hit;
    logic             in_rx;
    logic             in_ack;

    assign byte_done = scl_fall && (bit_cnt == FULL_CNT);
    assign addr_hit  = (shreg == {addr7, 1'b0});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        if (start_det) begin
            st_n = ST_ADDR;
        end else if (stop_det) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE, ST_IGNORE: st_n = st;
                ST_ADDR:     if (byte_done) st_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  st_n = ST_DATA;
                ST_DATA:     if (byte_done) st_n = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  st_n = ST_DATA;
                default:     st_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_rx     = (st == ST_ADDR) || (st == ST_DATA);
        in_ack    = (st == ST_ADDR_ACK) || (st == ST_DATA_ACK);
        sda_pull  = in_ack;
        evt_valid = (st == ST_DATA) && byte_done && !start_det && !stop_det;
        evt_byte  = shreg;
        if (pair_open)     evt_kind = KIND_DIV_LO;
        else if (shreg[7]) evt_kind = KIND_CTRL;
        else               evt_kind = KIND_DIV_HI;
    end

    // shifter, bit counter, divider-pair tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            pair_open <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt   <= '0;
            pair_open <= 1'b0;
        end else begin
            if (scl_rise && in_rx && (bit_cnt != FULL_CNT)) begin
                shreg   <= {shreg[6:0], sda_bit};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall && in_ack) bit_cnt <= '0;
            if (evt_valid) pair_open <= (evt_kind == KIND_DIV_HI);
        end
    end

    // acknowledge only begins right after an SCL fall
    assert_ack_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // acknowledge ends on an SCL fall, or a start/stop abort
    assert_ack_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

endmodule

// File: rtl/tcs_latch_bank.sv
module tcs_latch_bank
    import tcs_pkg::*;
#(
    parameter int DIV_W     = 11,
    parameter int DIV_RESET = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  byte_kind_t       evt_kind,
    input  logic [7:0]       evt_byte,
    output logic [DIV_W-1:0] div_ratio,
    output logic             pump_hi,
    output logic [2:0]       chan_off,
    output logic [2:0]       test_mode
);
    localparam int LO_W = 5;
    localparam int HI_W = DIV_W - LO_W;

    logic [HI_W-1:0] hi_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_pend   <= '0;
            div_ratio <= DIV_W'(DIV_RESET);
            pump_hi   <= 1'b0;
            chan_off  <= '0;
            test_mode <= '0;
        end else if (evt_valid) begin
            unique case (evt_kind)
                KIND_DIV_HI: hi_pend   <= evt_byte[HI_W-1:0];
                KIND_DIV_LO: div_ratio <= {hi_pend, evt_byte[7 -: LO_W]};
                KIND_CTRL: begin
                    pump_hi   <= evt_byte[6];
                    chan_off  <= {evt_byte[3], evt_byte[4], evt_byte[5]};
                    test_mode <= evt_byte[2:0];
                end
                default: ;
            endcase
        end
    end

    // the ratio only moves after a completed low byte
    assert_ratio_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ratio != $past(div_ratio)) |-> $past(evt_valid && (evt_kind == KIND_DIV_LO)));

    // control fields only move after a control byte
    assert_ctrl_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({pump_hi, chan_off, test_mode} != $past({pump_hi, chan_off, test_mode}))
        |-> $past(evt_valid && (evt_kind == KIND_CTRL)));

endmodule

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave
    import tcs_pkg::*;
#(
    parameter int         DIV_W       = 11,
    parameter int         DIV_RESET   = 1024,
    parameter logic [6:0] BASE_ADDR   = 7'h22,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel,
    output logic             sda_pull_o,
    output logic [DIV_W-1:0] div_ratio_o,
    output logic             pump_hi_o,
    output logic [2:0]       chan_off_o,
    output logic [2:0]       test_mode_o
);
    logic       scl_rise, scl_fall, sda_bit, start_det, stop_det;
    logic       fsm_pull;
    logic       evt_valid;
    byte_kind_t evt_kind;
    logic [7:0] evt_byte;
    logic [6:0] addr7;

    assign addr7 = {BASE_ADDR[6:1], BASE_ADDR[0] | addr_sel};

    tcs_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tcs_link_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr7     (addr7),
        .sda_pull  (fsm_pull),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_byte  (evt_byte)
    );

    tcs_latch_bank #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_byte  (evt_byte),
        .div_ratio (div_ratio_o),
        .pump_hi   (pump_hi_o),
        .chan_off  (chan_off_o),
        .test_mode (test_mode_o)
    );

    // power-on reset keeps the bus free
    assign sda_pull_o = rst_n & fsm_pull;

endmodule

// File: tb/sim_tuner_ctl_slave.sv
module sim_tuner_ctl_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_pull;
    logic [10:0] div_ratio;
    logic        pump_hi;
    logic [2:0]  chan_off;
    logic [2:0]  test_mode;
    logic        sda_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign sda_line = sda_h & ~sda_pull;

    tuner_ctl_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_h),
        .sda_i       (sda_line),
        .addr_sel    (addr_sel),
        .sda_pull_o  (sda_pull),
        .div_ratio_o (div_ratio),
        .pump_hi_o   (pump_hi),
        .chan_off_o  (chan_off),
        .test_mode_o (test_mode)
    );

    typedef struct packed {
        logic [2:0]  n;
        logic [7:0]  a;
        logic [7:0]  d0;
        logic [7:0]  d1;
        logic [7:0]  d2;
        logic [3:0]  ack;   // bit0 address, bit k data byte k-1
        logic [10:0] div;
        logic [7:0]  ctl;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{3'd3, 8'h44, 8'h2E, 8'hE0, 8'hA9, 4'b1111, 11'd1500, 8'hA9},
        '{3'd3, 8'h44, 8'hC0, 8'h3F, 8'hF8, 4'b1111, 11'd2047, 8'hC0},
        '{3'd1, 8'h44, 8'h20, 8'h00, 8'h00, 4'b0011, 11'd2047, 8'hC0},
        '{3'd1, 8'h44, 8'hBC, 8'h00, 8'h00, 4'b0011, 11'd2047, 8'hBC},
        '{3'd1, 8'h46, 8'h80, 8'h00, 8'h00, 4'b0000, 11'd2047, 8'hBC},
        '{3'd1, 8'h45, 8'h00, 8'h00, 8'h00, 4'b0000, 11'd2047, 8'hBC},
        '{3'd2, 8'h44, 8'h20, 8'h80, 8'h00, 4'b0111, 11'd1040, 8'hBC}
    };

    // expected port view of a control byte: pump, ch3, ch2, ch1, test
    function automatic logic [6:0] ctl_view(input logic [7:0] b);
        return {b[6], b[3], b[4], b[5], b[2:0]};
    endfunction

    function automatic logic [6:0] dut_view();
        return {pump_hi, chan_off, test_mode};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hq();
        scl_h = 1'b1; hq();
        sda_h = 1'b0; hq();
        scl_h = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hq();
        scl_h = 1'b1; hq();
        sda_h = 1'b1; hq();
        hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; hq();
            scl_h = 1'b1; hq();
            scl_h = 1'b0; hq();
        end
        sda_h = 1'b1; hq();
        scl_h = 1'b1; repeat (5) @(negedge clk);
        acked = (sda_line == 1'b0);
        repeat (5) @(negedge clk);
        scl_h = 1'b0; hq();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] d;

        // R9: bus activity under reset draws no acknowledge
        hq();
        bus_start();
        send_byte(8'h44, ack);
        chk("R9 no ack under reset", ack, 0);
        bus_stop();
        rst_n = 1'b1;
        hq();
        chk("R9 reset ratio", div_ratio, 11'd1024);
        chk("R9 reset control", dut_view(), 0);
        chk("R9 sda released", sda_pull, 0);

        // table: R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < 7; v++) begin
            bus_start();
            send_byte(VECS[v].a, ack);
            chk("R3 address ack", ack, VECS[v].ack[0]);
            for (int k = 0; k < 3; k++) begin
                if (k < int'(VECS[v].n)) begin
                    d = (k == 0) ? VECS[v].d0 : (k == 1) ? VECS[v].d1 : VECS[v].d2;
                    send_byte(d, ack);
                    chk("R10 data ack", ack, VECS[v].ack[k+1]);
                end
            end
            bus_stop();
            chk("R5 R6 R8 ratio", div_ratio, VECS[v].div);
            chk("R4 R7 R8 control", dut_view(), ctl_view(VECS[v].ctl));
        end

        // R1 R6: repeated start drops an open divider pair
        bus_start();
        send_byte(8'h44, ack);
        chk("R1 ack", ack, 1);
        send_byte(8'h2A, ack);
        chk("R4 ack", ack, 1);
        chk("R4 pending not applied", div_ratio, 11'd1040);
        sda_h = 1'b1; hq();
        scl_h = 1'b1; hq();
        sda_h = 1'b0; hq();
        scl_h = 1'b0; hq();
        send_byte(8'h44, ack);
        chk("R1 address after repeated start", ack, 1);
        send_byte(8'h98, ack);
        chk("R10 ack", ack, 1);
        bus_stop();
        chk("R6 ratio kept", div_ratio, 11'd1040);
        chk("R1 control after repeated start", dut_view(), ctl_view(8'h98));
        chk("R1 sda released after stop", sda_pull, 0);

        // R3: strap high moves the address
        addr_sel = 1'b1;
        hq();
        bus_start();
        send_byte(8'h46, ack);
        chk("R3 strap high ack", ack, 1);
        send_byte(8'h8F, ack);
        chk("R10 ack", ack, 1);
        bus_stop();
        chk("R7 control strap high", dut_view(), ctl_view(8'h8F));
        bus_start();
        send_byte(8'h44, ack);
        chk("R3 old address rejected", ack, 0);
        send_byte(8'h81, ack);
        chk("R3 ignored byte no ack", ack, 0);
        bus_stop();
        chk("R3 ignored byte no effect", dut_view(), ctl_view(8'h8F));

        finish_run();
    end

endmodule